// File: doc/BRIEF.md
# Counter Target Value Match Table

This block watches a signed 24-bit counter value and compares it against a table of up to 48 target values. Each table slot pairs a target value with an interrupt number. When comparison is running and the counter value newly equals an active slot's target, the block issues an interrupt request carrying that slot's number. If several slots match in the same cycle, their numbers come out one per cycle, lowest slot index first.

Software-side logic fills the table through a write port and sets how many slots are active. Start and stop pulses switch comparison on and off. A halt pulse from the counter's overflow and underflow logic also stops comparison, but the table contents are kept. The block has no reset path from the counter. A counter that jumps back to zero therefore leaves the table, the running state and any queued requests untouched, and comparison simply continues on the new value.

The interrupt request leaves on a valid/ready stream. While `irq_valid` is high and `irq_ready` is low, `irq_num` holds and the request stays offered. Matches found meanwhile wait in a pending set and follow once the request is taken. With `irq_ready` tied high, each request lasts one cycle.

Top module: `tvm_match_top`

## Requirements
- R1: After reset `irq_valid` is 0, `cmp_running` is 0, the active count is 0, and every slot holds value 0 with interrupt number 0.
- R2: A cycle with `tbl_wr_en` high and `tbl_wr_idx` below 48 stores `tbl_wr_value` (24-bit two's complement) and `tbl_wr_irq` into that slot. A write with an index of 48 or more changes no slot.
- R3: Only slots whose index is below the active count take part in matching. A write of `act_wr_count` above 48 sets the count to 48.
- R4: While running, if `cnt_value` sampled at a clock edge equals an active slot's value, then `irq_valid` is 1 after that same edge with `irq_num` equal to the slot's interrupt number (one register stage of latency).
- R5: A slot requests once when the counter value newly equals its target. Holding the counter at that value produces no further request. Leaving the value and coming back produces a new one.
- R6: When several slots become equal together, the lowest index is reported first and the others follow on successive accepted cycles in ascending index order.
- R7: While `irq_valid` is 1 and `irq_ready` is 0, `irq_valid` stays 1 and `irq_num` stays unchanged. Matches found meanwhile are delivered after the stall.
- R8: A `cmp_start` pulse sets `cmp_running`, and a `cmp_stop` pulse clears it. While stopped, no request is raised, and matches not yet offered are dropped.
- R9: A `cnt_halt` pulse clears `cmp_running` and takes priority over `cmp_start`. The table survives, and a later start matches against the same entries.
- R10: A jump of the counter to zero (a counter reset) does not change `cmp_running` or the table, and a slot holding 0 matches on that jump.
- R11: Comparison covers the full signed range: the extremes -8388608 and 8388607 each match exactly their own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Write one table slot |
| tbl_wr_idx | input | 6 | Slot index to write |
| tbl_wr_value | input | 24 | Signed target value to store |
| tbl_wr_irq | input | 6 | Interrupt number to store |
| act_wr_en | input | 1 | Write the active slot count |
| act_wr_count | input | 6 | New active count (clamped to 48) |
| cmp_start | input | 1 | Pulse: start comparison |
| cmp_stop | input | 1 | Pulse: stop comparison |
| cnt_halt | input | 1 | Pulse from overflow/underflow logic: stop comparison |
| cnt_value | input | 24 | Current signed counter value |
| irq_valid | output | 1 | Interrupt request offered |
| irq_ready | input | 1 | Consumer accepts the request |
| irq_num | output | 6 | Interrupt number of the offered request |
| cmp_running | output | 1 | Comparison enabled |

## Verification
A counter value presented before a clock edge shows up as a request right after that edge, so every match check samples at the falling edge that follows the one rising edge that took the value. Queued matches then come out one cycle apart, and the bench checks each following falling edge in turn. Start, stop and halt pulses act at the edge that samples them, so `cmp_running` is checked on the next falling edge. Under back-pressure, the held request is checked on each stalled cycle, and the queued numbers are checked on the cycles after `irq_ready` returns high.

// File: rtl/tvm_pkg.sv
package tvm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_e;
endpackage

// File: rtl/tvm_table.sv
module tvm_table #(
  parameter int DEPTH = 48,
  parameter int VAL_W = 24,
  parameter int IRQ_W = 6,
  parameter int IDX_W = 6,
  parameter int CNT_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [VAL_W-1:0]       wr_value,
  input  logic [IRQ_W-1:0]       wr_irq,
  input  logic                   act_wr_en,
  input  logic [CNT_W-1:0]       act_wr_count,
  input  logic                   cmp_en,
  input  logic [VAL_W-1:0]       cnt_value,
  output logic [DEPTH-1:0]       hit,
  output logic [DEPTH*IRQ_W-1:0] irq_flat
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (act_wr_en) begin
      active_q <= (act_wr_count > MAX_CNT) ? MAX_CNT : act_wr_count;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic [VAL_W-1:0] val_q;
    logic [IRQ_W-1:0] irq_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q <= '0;
        irq_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
        val_q <= wr_value;
        irq_q <= wr_irq;
      end
    end

    assign hit[gi] = cmp_en && (CNT_W'(gi) < active_q) && (val_q == cnt_value);
    assign irq_flat[gi*IRQ_W +: IRQ_W] = irq_q;
  end
endmodule

// File: rtl/tvm_queue.sv
module tvm_queue #(
  parameter int DEPTH = 48,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] hit,
  input  logic             flush,
  input  logic             take,
  output logic             pick_valid,
  output logic [IDX_W-1:0] pick_idx
);
  logic [DEPTH-1:0] hit_q;
  logic [DEPTH-1:0] pend_q;
  logic [DEPTH-1:0] cand;
  logic [DEPTH-1:0] sel_mask;
  logic             any;

  always_comb begin
    cand     = pend_q | (hit & ~hit_q);
    any      = |cand;
    pick_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) pick_idx = IDX_W'(i);
    end
    sel_mask           = '0;
    sel_mask[pick_idx] = any;
  end

  assign pick_valid = any && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= '0;
      pend_q <= '0;
    end else begin
      hit_q <= hit;
      if (flush) begin
        pend_q <= '0;
      end else if (take) begin
        pend_q <= cand & ~sel_mask;
      end else begin
        pend_q <= cand;
      end
    end
  end
endmodule

// File: rtl/tvm_run_ctl.sv
module tvm_run_ctl
  import tvm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic halt,
  output logic running,
  output logic flush
);
  run_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else if (halt || stop) begin
      st_q <= ST_IDLE;
    end else if (start) begin
      st_q <= ST_RUN;
    end
  end

  assign running = (st_q == ST_RUN);
  assign flush   = halt || stop || (st_q != ST_RUN);
endmodule

// File: rtl/tvm_match_top.sv
module tvm_match_top #(
  parameter int DEPTH = 48,
  parameter int VAL_W = 24,
  parameter int IRQ_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_wr_en,
  input  logic [IDX_W-1:0] tbl_wr_idx,
  input  logic [VAL_W-1:0] tbl_wr_value,
  input  logic [IRQ_W-1:0] tbl_wr_irq,
  input  logic             act_wr_en,
  input  logic [CNT_W-1:0] act_wr_count,
  input  logic             cmp_start,
  input  logic             cmp_stop,
  input  logic             cnt_halt,
  input  logic [VAL_W-1:0] cnt_value,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [IRQ_W-1:0] irq_num,
  output logic             cmp_running
);
  logic [DEPTH-1:0]       hit;
  logic [DEPTH*IRQ_W-1:0] irq_flat;
  logic                   flush;
  logic                   take;
  logic                   pick_valid;
  logic [IDX_W-1:0]       pick_idx;
  logic                   valid_q;
  logic [IRQ_W-1:0]       num_q;

  tvm_run_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (cmp_start),
    .stop    (cmp_stop),
    .halt    (cnt_halt),
    .running (cmp_running),
    .flush   (flush)
  );

  tvm_table #(
    .DEPTH (DEPTH),
    .VAL_W (VAL_W),
    .IRQ_W (IRQ_W),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (tbl_wr_en),
    .wr_idx       (tbl_wr_idx),
    .wr_value     (tbl_wr_value),
    .wr_irq       (tbl_wr_irq),
    .act_wr_en    (act_wr_en),
    .act_wr_count (act_wr_count),
    .cmp_en       (cmp_running),
    .cnt_value    (cnt_value),
    .hit          (hit),
    .irq_flat     (irq_flat)
  );

  assign take = !valid_q || irq_ready;

  tvm_queue #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .flush      (flush),
    .take       (take),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      num_q   <= '0;
    end else if (take) begin
      valid_q <= pick_valid;
      if (pick_valid) num_q <= irq_flat[int'(pick_idx)*IRQ_W +: IRQ_W];
    end
  end

  assign irq_valid = valid_q;
  assign irq_num   = num_q;
endmodule

// File: rtl/tvm_match_chk.sv
module tvm_match_chk #(
  parameter int IRQ_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_start,
  input logic             cmp_stop,
  input logic             cnt_halt,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic [IRQ_W-1:0] irq_num,
  input logic             cmp_running
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_num));

  // R9
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_halt |=> !cmp_running);

  // R8
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_stop |=> !cmp_running);

  // R8
  start_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_start && !cmp_stop && !cnt_halt |=> cmp_running);

  // R4
  rise_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(cmp_running) && !$past(cmp_stop) && !$past(cnt_halt));
endmodule

bind tvm_match_top tvm_match_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmp_start   (cmp_start),
  .cmp_stop    (cmp_stop),
  .cnt_halt    (cnt_halt),
  .irq_valid   (irq_valid),
  .irq_ready   (irq_ready),
  .irq_num     (irq_num),
  .cmp_running (cmp_running)
);

// File: tb/tvm_match_top_bench.sv
module tvm_match_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  // packing: [31:8] counter value, [7] request expected, [5:0] interrupt number
  localparam logic [31:0] VEC [NVEC] = '{
    {24'd1,       1'b0, 1'b0, 6'd0},   // no slot holds 1
    {24'd100,     1'b1, 1'b0, 6'd5},   // R4 slot 0
    {24'd100,     1'b1, 1'b0, 6'd20},  // R6 slot 3 follows slot 0
    {24'd100,     1'b0, 1'b0, 6'd0},   // R5 held value does not re-fire
    {24'd5,       1'b0, 1'b0, 6'd0},   // leave the value
    {24'd100,     1'b1, 1'b0, 6'd5},   // R5 return re-fires
    {24'd0,       1'b1, 1'b0, 6'd20},  // R6 queued slot 3 ahead of slot 4
    {24'd0,       1'b1, 1'b0, 6'd33},  // R6 slot 4 next
    {24'd77,      1'b0, 1'b0, 6'd0},   // R3 slot 5 beyond active count
    {24'h800000,  1'b1, 1'b0, 6'd9},   // R11 minimum
    {24'h7FFFFF,  1'b1, 1'b0, 6'd12},  // R11 maximum, R2 slot 2 unharmed
    {24'd55,      1'b0, 1'b0, 6'd0},   // R2 out-of-range write ignored
    {24'h800001,  1'b0, 1'b0, 6'd0}    // R11 neighbour of minimum
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_wr_en = 1'b0;
  logic [5:0]  tbl_wr_idx = '0;
  logic [23:0] tbl_wr_value = '0;
  logic [5:0]  tbl_wr_irq = '0;
  logic        act_wr_en = 1'b0;
  logic [5:0]  act_wr_count = '0;
  logic        cmp_start = 1'b0;
  logic        cmp_stop = 1'b0;
  logic        cnt_halt = 1'b0;
  logic [23:0] cnt_value = '0;
  logic        irq_valid;
  logic        irq_ready = 1'b1;
  logic [5:0]  irq_num;
  logic        cmp_running;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tvm_match_top u_tvm_match_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .tbl_wr_en    (tbl_wr_en),
    .tbl_wr_idx   (tbl_wr_idx),
    .tbl_wr_value (tbl_wr_value),
    .tbl_wr_irq   (tbl_wr_irq),
    .act_wr_en    (act_wr_en),
    .act_wr_count (act_wr_count),
    .cmp_start    (cmp_start),
    .cmp_stop     (cmp_stop),
    .cnt_halt     (cnt_halt),
    .cnt_value    (cnt_value),
    .irq_valid    (irq_valid),
    .irq_ready    (irq_ready),
    .irq_num      (irq_num),
    .cmp_running  (cmp_running)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_irq(input string req, input logic ev, input logic [5:0] en);
    chk({req, " valid"}, {31'd0, irq_valid}, {31'd0, ev});
    if (ev) chk({req, " num"}, {26'd0, irq_num}, {26'd0, en});
  endtask

  task automatic put(input int idx, input logic [23:0] v, input logic [5:0] n);
    tbl_wr_en = 1'b1; tbl_wr_idx = 6'(idx); tbl_wr_value = v; tbl_wr_irq = n;
    cyc();
    tbl_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 irq_valid", {31'd0, irq_valid}, 32'd0);
    chk("R1 running", {31'd0, cmp_running}, 32'd0);

    put(0, 24'd100, 6'd5);
    put(1, 24'h800000, 6'd9);
    put(2, 24'h7FFFFF, 6'd12);
    put(3, 24'd100, 6'd20);
    put(4, 24'd0, 6'd33);
    put(5, 24'd77, 6'd40);
    put(50, 24'd55, 6'd1);  // R2 index beyond table
    act_wr_en = 1'b1; act_wr_count = 6'd5;
    cyc();
    act_wr_en = 1'b0;
    cnt_value = 24'd1;
    cmp_start = 1'b1;
    cyc();
    cmp_start = 1'b0;
    chk("R8 running after start", {31'd0, cmp_running}, 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      cnt_value = VEC[i][31:8];
      cyc();
      chk_irq($sformatf("R4 vector %0d", i), VEC[i][7], VEC[i][5:0]);
    end

    // R7 back-pressure
    cnt_value = 24'd1; cyc();
    irq_ready = 1'b0;
    cnt_value = 24'd100; cyc();
    chk_irq("R7 offer", 1'b1, 6'd5);
    cnt_value = 24'd0; cyc();
    chk_irq("R7 hold 1", 1'b1, 6'd5);
    cyc();
    chk_irq("R7 hold 2", 1'b1, 6'd5);
    irq_ready = 1'b1; cyc();
    chk_irq("R7 queued slot 3", 1'b1, 6'd20);
    cyc();
    chk_irq("R7 queued slot 4", 1'b1, 6'd33);
    cyc();
    chk_irq("R7 drained", 1'b0, 6'd0);

    // R8 stop
    cnt_value = 24'd1;
    cmp_stop = 1'b1; cyc(); cmp_stop = 1'b0;
    chk("R8 running after stop", {31'd0, cmp_running}, 32'd0);
    cnt_value = 24'd100; cyc();
    chk_irq("R8 no request while stopped", 1'b0, 6'd0);
    cnt_value = 24'd1; cyc();

    // R9 halt beats start, table kept
    cmp_start = 1'b1; cnt_halt = 1'b1; cyc();
    cmp_start = 1'b0; cnt_halt = 1'b0;
    chk("R9 halt over start", {31'd0, cmp_running}, 32'd0);
    cmp_start = 1'b1; cyc(); cmp_start = 1'b0;
    cnt_value = 24'd100; cyc();
    chk_irq("R9 table kept slot 0", 1'b1, 6'd5);
    cyc();
    chk_irq("R9 table kept slot 3", 1'b1, 6'd20);
    cnt_value = 24'd1; cyc();
    cnt_halt = 1'b1; cyc(); cnt_halt = 1'b0;
    chk("R9 halt clears running", {31'd0, cmp_running}, 32'd0);
    cmp_start = 1'b1; cyc(); cmp_start = 1'b0;

    // R10 counter jumps to zero
    cnt_value = 24'h7FFFFF; cyc();
    chk_irq("R10 before jump", 1'b1, 6'd12);
    cnt_value = 24'd0; cyc();
    chk_irq("R10 zero slot fires", 1'b1, 6'd33);
    chk("R10 still running", {31'd0, cmp_running}, 32'd1);
    cnt_value = 24'd1; cyc();

    // R3 clamp of active count
    act_wr_en = 1'b1; act_wr_count = 6'd63; cyc(); act_wr_en = 1'b0;
    cnt_value = 24'd77; cyc();
    chk_irq("R3 clamped count enables slot 5", 1'b1, 6'd40);
    cnt_value = 24'd1; cyc();
    chk_irq("R3 idle after", 1'b0, 6'd0);

    finish_run();
  end
endmodule